// File: doc/BRIEF.md
# Shared Parallel Port Byte FIFO with Extended Control Register

This block is the byte buffer of an enhanced parallel port together with the register that controls it. One storage array of 16 entries sits behind every FIFO-mapped host address: the compatibility data alias, the ECP data alias, the ECP address alias and the test alias all reach the same store. Each entry holds the byte plus a one-bit tag that records whether the byte came in through the address alias (tag 1) or through any other path (tag 0). The cable handshake engine downstream reads the tag to tell command bytes from data bytes.

A direction input picks who fills and who drains the store. In forward mode the host writes bytes and the cable engine drains them from a fall-through head. In reverse mode the cable engine pushes bytes and the host reads them. The test alias gives the host both push and pop in either direction, so software can exercise the store without a cable. The extended control register holds a three-bit mode, a DMA enable, an error-interrupt enable and a service bit, and reports the full and empty state. Writing a different mode value empties the store. When DMA is enabled, a request line shows that the store can take a byte (forward) or give one (reverse).

Host accesses use a strobe, a 3-bit register selector and a write data bus. Read data is registered and is valid in the cycle after the read strobe.

Top module: `ppf_shared_fifo`

## Requirements
- R1: After synchronous reset the store is empty, the control register reads 0x01 (mode 0, all enables 0, empty flag set), `dma_req` is 0 and `port_has_data` is 0.
- R2: Selector codes 0 (compatibility data), 1 (ECP data), 2 (ECP address) and 3 (test) all feed one store. In forward mode bytes written through any mix of them reach `port_head_data` in write order, one per `port_pop`.
- R3: The store holds 16 entries. After 16 accepted pushes the full flag (control register bit 1) is set, and a further push is dropped without changing the stored contents or their order.
- R4: A pop while the store is empty is ignored: a host read of a FIFO alias returns 0x00, and the empty flag (bit 0) stays set.
- R5: With `dir_rev`=0, host writes to selectors 0-2 push and `port_pop` pops, while host reads of selectors 0-2 return 0x00 without popping and `port_push` is ignored. With `dir_rev`=1, `port_push` pushes and host reads of selectors 0-2 pop, while host writes to selectors 0-2 and `port_pop` are ignored.
- R6: Selector 3 (test) lets the host push by writing and pop by reading in both directions.
- R7: The control register at selector 4 has mode in bits 7:5, error-interrupt enable in bit 4, DMA enable in bit 3, service bit in bit 2, full in bit 1 and empty in bit 0. Bits 1:0 are read-only status and ignore writes. `mode` shows bits 7:5.
- R8: A control register write whose bits 7:5 differ from the current mode empties the store. A write that keeps the same mode leaves the contents in place.
- R9: `dma_req` is 1 only when DMA enable is set and, with `dir_rev`=0, the store is not full, or, with `dir_rev`=1, the store is not empty.
- R10: An entry's tag is 1 when it was written through selector 2, and 0 when written through selectors 0, 1 or 3. In reverse mode the tag is taken from `port_push_tag`. The head entry's tag appears on `port_head_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 3 | Register selector: 0-3 FIFO aliases, 4 control register |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| dir_rev | input | 1 | 0 forward (host fills), 1 reverse (port fills) |
| port_push | input | 1 | Cable engine push strobe (reverse) |
| port_push_data | input | DATA_W | Byte pushed by the cable engine |
| port_push_tag | input | 1 | Address tag for the pushed byte |
| port_pop | input | 1 | Cable engine pop strobe (forward) |
| port_head_data | output | DATA_W | Byte at the head of the store |
| port_head_tag | output | 1 | Tag of the head entry |
| port_has_data | output | 1 | Store not empty |
| port_has_space | output | 1 | Store not full |
| dma_req | output | 1 | DMA service request |
| mode | output | 3 | Current mode field |

## Verification
The assertions take for granted that the host never raises read and write in the same cycle. They also assume that a host access to the store is not paired with a cable-side access of the same kind in the same cycle; the host would win that collision and the cable access would be dropped. The bench drives one strobe per cycle, changes `dir_rev` only while the store is empty, and only pops from the cable side after checking `port_has_data`. With these limits each push and pop has one source, so the scoreboard's order is well defined.

// File: rtl/ppf_pkg.sv
package ppf_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_COMPAT = 3'd0,
    SEL_EDATA  = 3'd1,
    SEL_EADDR  = 3'd2,
    SEL_TEST   = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [2:0] mode;
    logic       nerr_en;
    logic       dma_en;
    logic       svc;
    logic       full;
    logic       empty;
  } ctrl_reg_t;

endpackage

// File: rtl/ppf_store.sv
module ppf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_tag,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic              head_tag,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W:0]  mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  // storage array without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= {push_tag, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_data = mem[rd_ptr][DATA_W-1:0];
  assign head_tag  = mem[rd_ptr][DATA_W];
  assign count     = cnt_q;

endmodule

// File: rtl/ppf_route.sv
module ppf_route
  import ppf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [SEL_W-1:0]  host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              dir_rev,
  input  logic              port_push,
  input  logic [DATA_W-1:0] port_push_data,
  input  logic              port_push_tag,
  input  logic              port_pop,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              push_tag,
  output logic              pop,
  output logic              host_pop,
  output logic              ctrl_wr
);

  logic is_test, is_stream, host_push, port_push_ok, port_pop_ok;

  assign is_test   = (host_addr == SEL_TEST);
  assign is_stream = (host_addr == SEL_COMPAT) || (host_addr == SEL_EDATA) ||
                     (host_addr == SEL_EADDR);

  // host side: stream aliases follow direction, test alias works both ways
  assign host_push = host_wr && (is_test || (is_stream && !dir_rev));
  assign host_pop  = host_rd && (is_test || (is_stream && dir_rev));

  // cable side yields to a host access of the same kind
  assign port_push_ok = port_push && dir_rev && !host_push;
  assign port_pop_ok  = port_pop && !dir_rev && !host_pop;

  assign push      = host_push || port_push_ok;
  assign push_data = host_push ? host_wdata : port_push_data;
  assign push_tag  = host_push ? (host_addr == SEL_EADDR) : port_push_tag;
  assign pop       = host_pop || port_pop_ok;
  assign ctrl_wr   = host_wr && (host_addr == SEL_CTRL);

endmodule

// File: rtl/ppf_ctrl_reg.sv
module ppf_ctrl_reg
  import ppf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  logic [7:0] wdata,
  input  logic      full,
  input  logic      empty,
  output ctrl_reg_t value,
  output logic      flush
);

  logic [2:0] mode_q;
  logic       nerr_q, dma_q, svc_q;

  assign flush = wr_en && (wdata[7:5] != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      nerr_q <= 1'b0;
      dma_q  <= 1'b0;
      svc_q  <= 1'b0;
    end else if (wr_en) begin
      mode_q <= wdata[7:5];
      nerr_q <= wdata[4];
      dma_q  <= wdata[3];
      svc_q  <= wdata[2];
    end
  end

  always_comb begin
    value.mode    = mode_q;
    value.nerr_en = nerr_q;
    value.dma_en  = dma_q;
    value.svc     = svc_q;
    value.full    = full;
    value.empty   = empty;
  end

endmodule

// File: rtl/ppf_shared_fifo.sv
module ppf_shared_fifo
  import ppf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [2:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              dir_rev,
  input  logic              port_push,
  input  logic [DATA_W-1:0] port_push_data,
  input  logic              port_push_tag,
  input  logic              port_pop,
  output logic [DATA_W-1:0] port_head_data,
  output logic              port_head_tag,
  output logic              port_has_data,
  output logic              port_has_space,
  output logic              dma_req,
  output logic [2:0]        mode
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              push, pop, push_tag, host_pop, ctrl_wr, flush;
  logic [DATA_W-1:0] push_data, head_data;
  logic              head_tag, is_full, is_empty;
  logic [CNT_W-1:0]  fill_count;
  ctrl_reg_t         ctrl_q;
  logic [2:0]        cur_mode;

  ppf_route #(.DATA_W(DATA_W)) u_route (
    .host_wr        (host_wr),
    .host_rd        (host_rd),
    .host_addr      (host_addr),
    .host_wdata     (host_wdata),
    .dir_rev        (dir_rev),
    .port_push      (port_push),
    .port_push_data (port_push_data),
    .port_push_tag  (port_push_tag),
    .port_pop       (port_pop),
    .push           (push),
    .push_data      (push_data),
    .push_tag       (push_tag),
    .pop            (pop),
    .host_pop       (host_pop),
    .ctrl_wr        (ctrl_wr)
  );

  ppf_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr_en (ctrl_wr),
    .wdata (host_wdata[7:0]),
    .full  (is_full),
    .empty (is_empty),
    .value (ctrl_q),
    .flush (flush)
  );

  ppf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .push      (push),
    .push_data (push_data),
    .push_tag  (push_tag),
    .pop       (pop),
    .head_data (head_data),
    .head_tag  (head_tag),
    .full      (is_full),
    .empty     (is_empty),
    .count     (fill_count)
  );

  // registered host read path
  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
    end else if (host_rd) begin
      if (host_addr == SEL_CTRL)
        host_rdata <= DATA_W'(ctrl_q);
      else if (host_pop && !is_empty)
        host_rdata <= head_data;
      else
        host_rdata <= '0;
    end
  end

  assign cur_mode       = ctrl_q.mode;
  assign mode           = cur_mode;
  assign port_head_data = head_data;
  assign port_head_tag  = head_tag;
  assign port_has_data  = !is_empty;
  assign port_has_space = !is_full;
  assign dma_req        = ctrl_q.dma_en && (dir_rev ? !is_empty : !is_full);

endmodule

// File: rtl/ppf_shared_fifo_chk.sv
module ppf_shared_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic             host_rd,
  input logic [2:0]       host_addr,
  input logic [7:0]       host_wbyte,
  input logic             dir_rev,
  input logic             port_push,
  input logic             port_pop,
  input logic             dma_req,
  input logic [CNT_W-1:0] count,
  input logic             full,
  input logic             empty,
  input logic [2:0]       cur_mode
);

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));

  // R3
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && host_wr && host_addr == 3'd3 && !port_pop) |=> full);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && host_rd && !host_wr && !port_push) |=> empty);

  // R5
  dir_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir_rev && port_push && !host_wr && !host_rd && !port_pop) |=> $stable(count));

  // R8
  mode_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && host_addr == 3'd4 && host_wbyte[7:5] != cur_mode) |=> empty);

  // R9
  dma_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dir_rev) |-> !full);

  // R9
  dma_rev_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req && dir_rev) |-> !empty);

endmodule

bind ppf_shared_fifo ppf_shared_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_wbyte (host_wdata[7:0]),
  .dir_rev    (dir_rev),
  .port_push  (port_push),
  .port_pop   (port_pop),
  .dma_req    (dma_req),
  .count      (fill_count),
  .full       (is_full),
  .empty      (is_empty),
  .cur_mode   (cur_mode)
);

// File: tb/ppf_shared_fifo_bench.sv
module ppf_shared_fifo_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       dir_rev = 1'b0;
  logic       port_push = 1'b0, port_push_tag = 1'b0, port_pop = 1'b0;
  logic [7:0] port_push_data = '0;
  logic [7:0] port_head_data;
  logic       port_head_tag, port_has_data, port_has_space, dma_req;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;
  logic [8:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ppf_shared_fifo #(.DATA_W(8), .DEPTH(DEPTH)) u_ppf_shared_fifo (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dir_rev(dir_rev), .port_push(port_push), .port_push_data(port_push_data),
    .port_push_tag(port_push_tag), .port_pop(port_pop),
    .port_head_data(port_head_data), .port_head_tag(port_head_tag),
    .port_has_data(port_has_data), .port_has_space(port_has_space),
    .dma_req(dma_req), .mode(mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d, input bit track);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    if (track) exp_q.push_back({(a == 3'd2), d});
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic ctrl_expect(input int exp, input string req);
    logic [7:0] v;
    host_read(3'd4, v);
    chk(v == exp[7:0], req, v, exp);
  endtask

  task automatic port_write(input logic [7:0] d, input logic t);
    @(negedge clk);
    port_push = 1'b1; port_push_data = d; port_push_tag = t;
    @(negedge clk);
    port_push = 1'b0;
  endtask

  // scoreboard monitor: pops the cable side and compares against the queue
  task automatic port_drain(input string req);
    while (exp_q.size() > 0) begin
      logic [8:0] e;
      e = exp_q.pop_front();
      @(negedge clk);
      chk(port_has_data == 1'b1, req, port_has_data, 1);
      chk({port_head_tag, port_head_data} == e, req, {port_head_tag, port_head_data}, e);
      port_pop = 1'b1;
      @(negedge clk);
      port_pop = 1'b0;
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 4000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk(dma_req == 1'b0, "R1 dma_req", dma_req, 0);
    chk(port_has_data == 1'b0, "R1 has_data", port_has_data, 0);
    chk(mode == 3'd0, "R1 mode", mode, 0);
    ctrl_expect(8'h01, "R1 ctrl reset");

    // R2 R10 all aliases feed one store in order, tag from address alias
    host_write(3'd0, 8'hA0, 1);
    host_write(3'd1, 8'hA1, 1);
    host_write(3'd2, 8'hA2, 1);
    host_write(3'd3, 8'hA3, 1);
    host_write(3'd2, 8'hA4, 1);
    ctrl_expect(8'h00, "R2 not empty");
    port_drain("R2 R10 order and tag");
    ctrl_expect(8'h01, "R2 empty after drain");

    // R3 fill to 16, extra push dropped
    for (int i = 0; i < DEPTH; i++) host_write(3'd1, 8'(8'h10 + i), 1);
    ctrl_expect(8'h02, "R3 full flag");
    chk(port_has_space == 1'b0, "R3 no space", port_has_space, 0);
    host_write(3'd1, 8'hEE, 0);
    host_write(3'd3, 8'hEF, 0);
    port_drain("R3 contents after overflow");

    // R4 pop on empty ignored
    @(negedge clk); port_pop = 1'b1;
    @(negedge clk); port_pop = 1'b0;
    ctrl_expect(8'h01, "R4 port pop on empty");
    host_read(3'd3, v);
    chk(v == 8'h00, "R4 test read on empty", v, 0);
    ctrl_expect(8'h01, "R4 still empty");

    // R5 forward: stream read does not pop, port_push ignored
    host_write(3'd1, 8'h5A, 1);
    host_read(3'd1, v);
    chk(v == 8'h00, "R5 fwd stream read", v, 0);
    port_write(8'h77, 1'b0);
    port_drain("R5 fwd single entry kept");
    ctrl_expect(8'h01, "R5 fwd empty");

    // R6 test alias forward round trip
    host_write(3'd3, 8'hC3, 0);
    host_read(3'd3, v);
    chk(v == 8'hC3, "R6 test fwd", v, 8'hC3);

    // R7 control register fields, status bits read-only
    host_write(3'd4, 8'hFF, 0);
    ctrl_expect(8'hFD, "R7 ctrl readback");
    chk(mode == 3'd7, "R7 mode port", mode, 7);
    chk(dma_req == 1'b1, "R9 fwd empty with dma", dma_req, 1);

    // R8 same mode keeps contents, new mode flushes
    host_write(3'd1, 8'h31, 0);
    host_write(3'd1, 8'h32, 0);
    host_write(3'd4, 8'hE0, 0);
    ctrl_expect(8'hE0, "R8 same mode no flush");
    host_write(3'd4, 8'h20, 0);
    ctrl_expect(8'h21, "R8 new mode flush");
    chk(port_has_data == 1'b0, "R8 port empty", port_has_data, 0);

    // R9 DMA request in forward
    host_write(3'd4, 8'h08, 0);
    chk(dma_req == 1'b1, "R9 fwd space", dma_req, 1);
    for (int i = 0; i < DEPTH; i++) host_write(3'd0, 8'(8'h40 + i), 1);
    @(negedge clk);
    chk(dma_req == 1'b0, "R9 fwd full", dma_req, 0);
    port_drain("R9 drain");
    @(negedge clk);
    chk(dma_req == 1'b1, "R9 fwd space again", dma_req, 1);

    // R5 reverse direction
    dir_rev = 1'b1;
    @(negedge clk);
    chk(dma_req == 1'b0, "R9 rev empty", dma_req, 0);
    host_write(3'd1, 8'h55, 0);
    ctrl_expect(8'h09, "R5 rev host write ignored");
    port_write(8'h61, 1'b0);
    chk(dma_req == 1'b1, "R9 rev data", dma_req, 1);
    chk(port_head_tag == 1'b0, "R10 rev tag 0", port_head_tag, 0);
    port_write(8'h62, 1'b1);
    @(negedge clk); port_pop = 1'b1;
    @(negedge clk); port_pop = 1'b0;
    host_read(3'd0, v);
    chk(v == 8'h61, "R5 rev first byte", v, 8'h61);
    chk(port_head_tag == 1'b1, "R10 rev tag 1", port_head_tag, 1);
    host_read(3'd2, v);
    chk(v == 8'h62, "R5 rev second byte", v, 8'h62);
    host_read(3'd1, v);
    chk(v == 8'h00, "R4 rev read empty", v, 0);
    ctrl_expect(8'h09, "R4 rev still empty");

    // R6 test alias reverse round trip
    host_write(3'd3, 8'hD6, 0);
    host_read(3'd3, v);
    chk(v == 8'hD6, "R6 test rev", v, 8'hD6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule